// File: doc/BRIEF.md
# Windowed Slow Receive Gain Controller

This block steers the gain index of one receive channel. It keeps the most recent power measurement, which is given in dB below full scale so that a larger number means a weaker signal. Once per update period it compares that measurement with two nested threshold windows and moves the index by the step size that belongs to the band the power falls in. The inner window is set by two thresholds. The outer window is built from the inner thresholds plus two offsets, and a crossing of the outer window uses larger step sizes.

Overload events come from the ADC, from the limiter and from digital saturation. They are counted during each update period. When enough large overloads have been counted, the gain drops. When enough small events have been counted, any increase is blocked. Large overloads can also be set to cut the gain at once. After the channel enters receive, an attack delay keeps the controller idle. A sync input can restart the update period.

The power input is a valid/ready stream. `pwr_ready` equals `rx_active`, so samples offered outside the receive state are held back by the source and are not consumed. A beat is taken on any cycle where both `pwr_valid` and `pwr_ready` are high. No back-pressure is applied during receive. All other pins are plain level signals.

Top module: `slow_agc_ctrl`

## Requirements
- R1: After reset `gain_idx` equals the parameter INIT_GAIN, `gain_chg` is 0, and `st_attack` and `st_run` are 0.
- R2: At an update tick, power below `cfg_thr_in_hi` (a stronger signal) lowers the index by `cfg_step_in_dec`. Power above `cfg_thr_in_lo` raises it by `cfg_step_in_inc`. Power equal to either threshold, or between them, leaves the index unchanged.
- R3: The outer high level is `cfg_thr_in_hi - cfg_ofs_out_hi`, floored at 0, and the outer low level is `cfg_thr_in_lo + cfg_ofs_out_lo`. Power strictly below the outer high level lowers the index by `cfg_step_out_dec`. Power strictly above the outer low level raises it by `cfg_step_out_inc`. An outer crossing takes precedence over an inner crossing.
- R4: Large ADC overloads counted in the period reaching a nonzero `cfg_lim_adc_lg` lower the index by `cfg_step_lg_adc` at the tick. This outranks every other decision.
- R5: Large limiter overloads reaching a nonzero `cfg_lim_lmt_lg` lower the index by `cfg_step_lg_lmt`. This ranks below R4 and above the threshold decisions.
- R6: Small ADC overloads reaching `cfg_lim_adc_sm`, small limiter overloads reaching `cfg_lim_lmt_sm`, or digital saturation events reaching `cfg_lim_dsat` (each limit nonzero) block any increase in that period, and `st_inc_block` is then 1.
- R7: Event counters clear at every update tick and while the controller is not running, so counts do not carry from one period to the next. A limit of 0 disables its check.
- R8: With `cfg_imm_adc` set, each running cycle with `ovl_adc_lg` high lowers the index by `cfg_step_lg_adc` on the next edge, and the event is not counted. `cfg_imm_lmt` does the same for `ovl_lmt_lg` with `cfg_step_lg_lmt`. An immediate cut replaces a tick decision in the same cycle.
- R9: While `rx_active` is low the index holds. After `rx_active` rises, the controller is idle (`st_attack` = 1) until the `cfg_attack_dly` countdown ends, and it runs from `cfg_attack_dly + 2` edges after the rise. The first tick falls in the `cfg_period`-th running cycle, and a tick follows every `cfg_period` cycles after that (0 is treated as 1).
- R10: With `cfg_sync_en` set, a rising edge of `sync_in` while running restarts the period, so the next tick falls `cfg_period` cycles after the edge cycle.
- R11: The index never goes below 0 and is never raised above `cfg_max_gain`. An overshooting step stops at the limit.
- R12: `gain_chg` is high for exactly the cycles in which `gain_idx` differs from its value in the previous cycle.
- R13: `pwr_ready` equals `rx_active`. Tick decisions based on thresholds need a power beat accepted since receive was last entered, and the latest beat is the one used.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_active | input | 1 | Channel is in the receive state |
| sync_in | input | 1 | Period restart control |
| pwr_valid | input | 1 | Power beat valid |
| pwr_ready | output | 1 | Power beat accepted (equals rx_active) |
| pwr_dbfs | input | 7 | Power, dB below full scale |
| ovl_adc_lg | input | 1 | Large ADC overload event |
| ovl_adc_sm | input | 1 | Small ADC overload event |
| ovl_lmt_lg | input | 1 | Large limiter overload event |
| ovl_lmt_sm | input | 1 | Small limiter overload event |
| dig_sat | input | 1 | Digital saturation event |
| cfg_max_gain | input | GAIN_W | Highest allowed index |
| cfg_thr_in_hi | input | 7 | Inner high threshold |
| cfg_thr_in_lo | input | 7 | Inner low threshold |
| cfg_ofs_out_hi | input | 4 | Outer high offset |
| cfg_ofs_out_lo | input | 4 | Outer low offset |
| cfg_step_in_dec | input | 3 | Inner high decrease step |
| cfg_step_in_inc | input | 3 | Inner low increase step |
| cfg_step_out_dec | input | 4 | Outer high decrease step |
| cfg_step_out_inc | input | 4 | Outer low increase step |
| cfg_step_lg_adc | input | 4 | Large ADC overload step |
| cfg_step_lg_lmt | input | 3 | Large limiter overload step |
| cfg_lim_adc_lg | input | 4 | Large ADC overload count limit |
| cfg_lim_lmt_lg | input | 4 | Large limiter overload count limit |
| cfg_lim_adc_sm | input | 4 | Small ADC overload count limit |
| cfg_lim_lmt_sm | input | 4 | Small limiter overload count limit |
| cfg_lim_dsat | input | 4 | Digital saturation count limit |
| cfg_imm_adc | input | 1 | Immediate cut on large ADC overload |
| cfg_imm_lmt | input | 1 | Immediate cut on large limiter overload |
| cfg_attack_dly | input | 6 | Attack delay count |
| cfg_sync_en | input | 1 | Enable period restart by sync_in |
| cfg_period | input | PER_W | Update period in cycles |
| gain_idx | output | GAIN_W | Gain index |
| gain_chg | output | 1 | Index changed this cycle |
| st_attack | output | 1 | Attack delay in progress |
| st_run | output | 1 | Controller running |
| st_inc_block | output | 1 | Increase blocked by small events |

## Verification
The bench builds the block with GAIN_W = 7, INIT_GAIN = 40 and PER_W = 8. It drives a period of 8 cycles, an attack delay of 3 and a ceiling of 60. The short period lets a whole decision round, from the rise of receive to the tick, fit in about twenty cycles. Starting at 40 with steps of up to 9 means the ceiling of 60 and the floor of 0 are both reached within a few updates, so clamping on either side is exercised along with exact threshold equality and the ordering between overload and window decisions.

// File: rtl/agc_pkg.sv
package agc_pkg;
  localparam int THR_W   = 7;
  localparam int OFS_W   = 4;
  localparam int ISTEP_W = 3;
  localparam int OSTEP_W = 4;
  localparam int STEP_W  = 4;
  localparam int ECNT_W  = 4;
  localparam int ADLY_W  = 6;

  localparam int EV_ADC_LG = 0;
  localparam int EV_LMT_LG = 1;
  localparam int EV_ADC_SM = 2;
  localparam int EV_LMT_SM = 3;
  localparam int EV_DSAT   = 4;
  localparam int NUM_EV    = 5;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_ATTACK = 2'd1,
    PH_RUN    = 2'd2
  } agc_phase_e;
endpackage

// File: rtl/agc_evt_ctr.sv
module agc_evt_ctr #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  input  logic [W-1:0] lim,
  output logic         reached
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     cnt_q <= '0;
    else if (clr)                   cnt_q <= '0;
    else if (inc && (cnt_q != '1))  cnt_q <= cnt_q + 1'b1;
  end

  assign reached = (lim != '0) && (cnt_q >= lim);
endmodule

// File: rtl/agc_phase_timer.sv
module agc_phase_timer
  import agc_pkg::*;
#(
  parameter int DLY_W = 6,
  parameter int PER_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_active,
  input  logic             sync_in,
  input  logic             sync_en,
  input  logic [DLY_W-1:0] attack_dly,
  input  logic [PER_W-1:0] period,
  output logic             run,
  output logic             attack,
  output logic             tick
);
  agc_phase_e       ph_q;
  logic [DLY_W-1:0] acnt_q;
  logic [PER_W-1:0] pcnt_q;
  logic [PER_W-1:0] per_last;
  logic             sync_q;
  logic             sync_rise;

  assign per_last  = (period == '0) ? '0 : period - 1'b1;
  assign run       = rx_active && (ph_q == PH_RUN);
  assign attack    = rx_active && (ph_q == PH_ATTACK);
  assign sync_rise = run && sync_en && sync_in && !sync_q;
  assign tick      = run && !sync_rise && (pcnt_q >= per_last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 1'b0;
    end else begin
      sync_q <= sync_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= PH_IDLE;
      acnt_q <= '0;
      pcnt_q <= '0;
    end else if (!rx_active) begin
      ph_q   <= PH_IDLE;
      acnt_q <= '0;
      pcnt_q <= '0;
    end else begin
      unique case (ph_q)
        PH_IDLE: begin
          acnt_q <= attack_dly;
          ph_q   <= PH_ATTACK;
        end
        PH_ATTACK: begin
          if (acnt_q == '0) begin
            ph_q   <= PH_RUN;
            pcnt_q <= '0;
          end else begin
            acnt_q <= acnt_q - 1'b1;
          end
        end
        PH_RUN: begin
          if (sync_rise || tick) pcnt_q <= '0;
          else                   pcnt_q <= pcnt_q + 1'b1;
        end
        default: ph_q <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/agc_step_select.sv
module agc_step_select
  import agc_pkg::*;
(
  input  logic [THR_W-1:0]   pwr,
  input  logic [THR_W-1:0]   thr_in_hi,
  input  logic [THR_W-1:0]   thr_in_lo,
  input  logic [OFS_W-1:0]   ofs_out_hi,
  input  logic [OFS_W-1:0]   ofs_out_lo,
  input  logic [ISTEP_W-1:0] step_in_dec,
  input  logic [ISTEP_W-1:0] step_in_inc,
  input  logic [OSTEP_W-1:0] step_out_dec,
  input  logic [OSTEP_W-1:0] step_out_inc,
  input  logic [STEP_W-1:0]  step_lg_adc,
  input  logic [ISTEP_W-1:0] step_lg_lmt,
  input  logic [NUM_EV-1:0]  reach,
  output logic               sel_dec,
  output logic               sel_inc,
  output logic [STEP_W-1:0]  sel_amt,
  output logic               inc_block
);
  localparam int LVL_W = THR_W + 1;

  logic [LVL_W-1:0] lvl_out_hi;
  logic [LVL_W-1:0] lvl_out_lo;
  logic             strong_out, strong_in, weak_out, weak_in;

  always_comb begin
    if (thr_in_hi >= THR_W'(ofs_out_hi))
      lvl_out_hi = {1'b0, thr_in_hi - THR_W'(ofs_out_hi)};
    else
      lvl_out_hi = '0;
    lvl_out_lo = {1'b0, thr_in_lo} + LVL_W'(ofs_out_lo);
  end

  assign strong_out = {1'b0, pwr} < lvl_out_hi;
  assign strong_in  = pwr < thr_in_hi;
  assign weak_out   = {1'b0, pwr} > lvl_out_lo;
  assign weak_in    = pwr > thr_in_lo;
  assign inc_block  = reach[EV_ADC_SM] | reach[EV_LMT_SM] | reach[EV_DSAT];

  always_comb begin
    sel_dec = 1'b0;
    sel_inc = 1'b0;
    sel_amt = '0;
    if (reach[EV_ADC_LG]) begin
      sel_dec = 1'b1;
      sel_amt = step_lg_adc;
    end else if (reach[EV_LMT_LG]) begin
      sel_dec = 1'b1;
      sel_amt = STEP_W'(step_lg_lmt);
    end else if (strong_out) begin
      sel_dec = 1'b1;
      sel_amt = STEP_W'(step_out_dec);
    end else if (strong_in) begin
      sel_dec = 1'b1;
      sel_amt = STEP_W'(step_in_dec);
    end else if (weak_out && !inc_block) begin
      sel_inc = 1'b1;
      sel_amt = STEP_W'(step_out_inc);
    end else if (weak_in && !inc_block) begin
      sel_inc = 1'b1;
      sel_amt = STEP_W'(step_in_inc);
    end
  end
endmodule

// File: rtl/agc_gain_reg.sv
module agc_gain_reg #(
  parameter int GAIN_W    = 7,
  parameter int AMT_W     = 4,
  parameter int INIT_GAIN = 40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [GAIN_W-1:0] max_gain,
  input  logic              do_dec,
  input  logic              do_inc,
  input  logic [AMT_W-1:0]  amt,
  output logic [GAIN_W-1:0] gain,
  output logic              chg
);
  localparam logic [GAIN_W-1:0] INIT_VAL = GAIN_W'(INIT_GAIN);

  logic [GAIN_W-1:0] gain_q, gain_d;
  logic [GAIN_W:0]   sum;

  always_comb begin
    sum    = {1'b0, gain_q} + (GAIN_W+1)'(amt);
    gain_d = gain_q;
    if (do_dec) begin
      gain_d = (gain_q > GAIN_W'(amt)) ? gain_q - GAIN_W'(amt) : '0;
    end else if (do_inc) begin
      gain_d = (sum > {1'b0, max_gain}) ? max_gain : sum[GAIN_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gain_q <= INIT_VAL;
      chg    <= 1'b0;
    end else begin
      gain_q <= gain_d;
      chg    <= (gain_d != gain_q);
    end
  end

  assign gain = gain_q;
endmodule

// File: rtl/slow_agc_ctrl.sv
module slow_agc_ctrl
  import agc_pkg::*;
#(
  parameter int GAIN_W    = 7,
  parameter int INIT_GAIN = 40,
  parameter int PER_W     = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rx_active,
  input  logic               sync_in,
  input  logic               pwr_valid,
  output logic               pwr_ready,
  input  logic [6:0]         pwr_dbfs,
  input  logic               ovl_adc_lg,
  input  logic               ovl_adc_sm,
  input  logic               ovl_lmt_lg,
  input  logic               ovl_lmt_sm,
  input  logic               dig_sat,
  input  logic [GAIN_W-1:0]  cfg_max_gain,
  input  logic [6:0]         cfg_thr_in_hi,
  input  logic [6:0]         cfg_thr_in_lo,
  input  logic [3:0]         cfg_ofs_out_hi,
  input  logic [3:0]         cfg_ofs_out_lo,
  input  logic [2:0]         cfg_step_in_dec,
  input  logic [2:0]         cfg_step_in_inc,
  input  logic [3:0]         cfg_step_out_dec,
  input  logic [3:0]         cfg_step_out_inc,
  input  logic [3:0]         cfg_step_lg_adc,
  input  logic [2:0]         cfg_step_lg_lmt,
  input  logic [3:0]         cfg_lim_adc_lg,
  input  logic [3:0]         cfg_lim_lmt_lg,
  input  logic [3:0]         cfg_lim_adc_sm,
  input  logic [3:0]         cfg_lim_lmt_sm,
  input  logic [3:0]         cfg_lim_dsat,
  input  logic               cfg_imm_adc,
  input  logic               cfg_imm_lmt,
  input  logic [5:0]         cfg_attack_dly,
  input  logic               cfg_sync_en,
  input  logic [PER_W-1:0]   cfg_period,
  output logic [GAIN_W-1:0]  gain_idx,
  output logic               gain_chg,
  output logic               st_attack,
  output logic               st_run,
  output logic               st_inc_block
);
  logic             run, tick;
  logic [THR_W-1:0] pwr_q;
  logic             have_pwr_q;
  logic             sel_dec, sel_inc, inc_block;
  logic [STEP_W-1:0] sel_amt, amt;
  logic             imm_adc_hit, imm_lmt_hit, imm_hit;
  logic             do_dec, do_inc;
  logic             ctr_clr;
  logic [NUM_EV-1:0] ev_raw, ev_inc, ev_reach;
  logic [ECNT_W-1:0] ev_lim [NUM_EV];

  assign pwr_ready = rx_active;

  // R13: latest accepted power beat, forgotten outside receive
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pwr_q      <= '0;
      have_pwr_q <= 1'b0;
    end else if (!rx_active) begin
      have_pwr_q <= 1'b0;
    end else if (pwr_valid) begin
      pwr_q      <= pwr_dbfs;
      have_pwr_q <= 1'b1;
    end
  end

  agc_phase_timer #(.DLY_W(ADLY_W), .PER_W(PER_W)) u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .rx_active  (rx_active),
    .sync_in    (sync_in),
    .sync_en    (cfg_sync_en),
    .attack_dly (cfg_attack_dly),
    .period     (cfg_period),
    .run        (run),
    .attack     (st_attack),
    .tick       (tick)
  );

  // Event sources and limits, indexed by the package event numbers
  assign ev_raw[EV_ADC_LG] = ovl_adc_lg && !cfg_imm_adc;
  assign ev_raw[EV_LMT_LG] = ovl_lmt_lg && !cfg_imm_lmt;
  assign ev_raw[EV_ADC_SM] = ovl_adc_sm;
  assign ev_raw[EV_LMT_SM] = ovl_lmt_sm;
  assign ev_raw[EV_DSAT]   = dig_sat;

  assign ev_lim[EV_ADC_LG] = cfg_lim_adc_lg;
  assign ev_lim[EV_LMT_LG] = cfg_lim_lmt_lg;
  assign ev_lim[EV_ADC_SM] = cfg_lim_adc_sm;
  assign ev_lim[EV_LMT_SM] = cfg_lim_lmt_sm;
  assign ev_lim[EV_DSAT]   = cfg_lim_dsat;

  assign ev_inc  = ev_raw & {NUM_EV{run}};
  assign ctr_clr = tick || !run;  // R7

  for (genvar i = 0; i < NUM_EV; i++) begin : g_evt
    agc_evt_ctr #(.W(ECNT_W)) u_ctr (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (ctr_clr),
      .inc     (ev_inc[i]),
      .lim     (ev_lim[i]),
      .reached (ev_reach[i])
    );
  end

  agc_step_select u_sel (
    .pwr          (pwr_q),
    .thr_in_hi    (cfg_thr_in_hi),
    .thr_in_lo    (cfg_thr_in_lo),
    .ofs_out_hi   (cfg_ofs_out_hi),
    .ofs_out_lo   (cfg_ofs_out_lo),
    .step_in_dec  (cfg_step_in_dec),
    .step_in_inc  (cfg_step_in_inc),
    .step_out_dec (cfg_step_out_dec),
    .step_out_inc (cfg_step_out_inc),
    .step_lg_adc  (cfg_step_lg_adc),
    .step_lg_lmt  (cfg_step_lg_lmt),
    .reach        (ev_reach),
    .sel_dec      (sel_dec),
    .sel_inc      (sel_inc),
    .sel_amt      (sel_amt),
    .inc_block    (inc_block)
  );

  // R8: immediate cuts outrank the tick decision
  assign imm_adc_hit = run && cfg_imm_adc && ovl_adc_lg;
  assign imm_lmt_hit = run && cfg_imm_lmt && ovl_lmt_lg;
  assign imm_hit     = imm_adc_hit || imm_lmt_hit;

  always_comb begin
    if (imm_adc_hit)      amt = cfg_step_lg_adc;
    else if (imm_lmt_hit) amt = STEP_W'(cfg_step_lg_lmt);
    else                  amt = sel_amt;
  end

  // R4/R5 outrank the windows and the counted small events (R6)
  // only block increases; a threshold decision needs a power beat (R13)
  assign do_dec = imm_hit || (tick && sel_dec && (have_pwr_q || ev_reach[EV_ADC_LG] || ev_reach[EV_LMT_LG]));
  assign do_inc = !imm_hit && tick && have_pwr_q && sel_inc;

  agc_gain_reg #(.GAIN_W(GAIN_W), .AMT_W(STEP_W), .INIT_GAIN(INIT_GAIN)) u_gain (
    .clk      (clk),
    .rst_n    (rst_n),
    .max_gain (cfg_max_gain),
    .do_dec   (do_dec),
    .do_inc   (do_inc),
    .amt      (amt),
    .gain     (gain_idx),
    .chg      (gain_chg)
  );

  assign st_run       = run;
  assign st_inc_block = run && inc_block;
endmodule

// File: rtl/slow_agc_ctrl_checker.sv
module slow_agc_ctrl_checker #(
  parameter int GAIN_W = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rx_active,
  input logic [GAIN_W-1:0] gain_idx,
  input logic              gain_chg,
  input logic              st_attack,
  input logic [GAIN_W-1:0] cfg_max_gain
);
  assert_strobe_on_change_R12: assert property (@(posedge clk) disable iff (!rst_n)
    gain_chg |-> (gain_idx != $past(gain_idx)));

  assert_no_silent_change_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !gain_chg |-> (gain_idx == $past(gain_idx)));

  assert_rise_within_ceiling_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (gain_idx > $past(gain_idx)) |-> (gain_idx <= $past(cfg_max_gain)));

  assert_hold_in_attack_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(st_attack) |-> $stable(gain_idx));

  assert_hold_outside_rx_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rx_active) |-> $stable(gain_idx));
endmodule

bind slow_agc_ctrl slow_agc_ctrl_checker #(.GAIN_W(GAIN_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .rx_active    (rx_active),
  .gain_idx     (gain_idx),
  .gain_chg     (gain_chg),
  .st_attack    (st_attack),
  .cfg_max_gain (cfg_max_gain)
);

// File: tb/slow_agc_ctrl_test.sv
`timescale 1ns/1ps
module slow_agc_ctrl_test;
  localparam int GAIN_W = 7;
  localparam int INIT   = 40;
  localparam int PER    = 8;
  localparam int ADLY   = 3;
  localparam int NV     = 31;
  // columns: power, large adc, large lmt, small adc, small lmt, dsat, expected gain
  localparam int TBL [NV][7] = '{
    '{30,0,0,0,0,0,40}, '{17,0,0,0,0,0,38}, '{10,0,0,0,0,0,33},
    '{45,0,0,0,0,0,36}, '{55,0,0,0,0,0,43}, '{55,0,0,2,0,0,43},
    '{55,0,0,1,0,0,50}, '{45,0,0,0,0,4,50}, '{55,0,0,0,2,0,50},
    '{30,3,0,0,0,0,41}, '{30,2,0,0,0,0,41}, '{55,0,2,0,0,0,37},
    '{20,0,0,0,0,0,37}, '{40,0,0,0,0,0,37}, '{14,0,0,0,0,0,35},
    '{48,0,0,0,0,0,38}, '{17,3,0,0,0,0,29}, '{60,0,0,0,0,0,36},
    '{60,0,0,0,0,0,43}, '{60,0,0,0,0,0,50}, '{60,0,0,0,0,0,57},
    '{60,0,0,0,0,0,60}, '{60,0,0,0,0,0,60}, '{30,3,2,0,0,0,51},
    '{5,3,0,0,0,0,42},  '{5,3,0,0,0,0,33},  '{5,3,0,0,0,0,24},
    '{5,3,0,0,0,0,15},  '{5,3,0,0,0,0,6},   '{5,3,0,0,0,0,0},
    '{5,3,0,0,0,0,0}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx_active = 1'b0, sync_in = 1'b0, pwr_valid = 1'b0;
  logic pwr_ready;
  logic [6:0] pwr_dbfs = '0;
  logic ovl_adc_lg = 1'b0, ovl_adc_sm = 1'b0, ovl_lmt_lg = 1'b0, ovl_lmt_sm = 1'b0, dig_sat = 1'b0;
  logic cfg_imm_adc = 1'b0, cfg_imm_lmt = 1'b0, cfg_sync_en = 1'b0;
  logic [GAIN_W-1:0] gain_idx;
  logic gain_chg, st_attack, st_run, st_inc_block;
  int checks = 0, failures = 0, g = INIT;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  slow_agc_ctrl #(.GAIN_W(GAIN_W), .INIT_GAIN(INIT), .PER_W(8)) uut (
    .clk(clk), .rst_n(rst_n), .rx_active(rx_active), .sync_in(sync_in),
    .pwr_valid(pwr_valid), .pwr_ready(pwr_ready), .pwr_dbfs(pwr_dbfs),
    .ovl_adc_lg(ovl_adc_lg), .ovl_adc_sm(ovl_adc_sm), .ovl_lmt_lg(ovl_lmt_lg),
    .ovl_lmt_sm(ovl_lmt_sm), .dig_sat(dig_sat),
    .cfg_max_gain(7'd60), .cfg_thr_in_hi(7'd20), .cfg_thr_in_lo(7'd40),
    .cfg_ofs_out_hi(4'd6), .cfg_ofs_out_lo(4'd8),
    .cfg_step_in_dec(3'd2), .cfg_step_in_inc(3'd3),
    .cfg_step_out_dec(4'd5), .cfg_step_out_inc(4'd7),
    .cfg_step_lg_adc(4'd9), .cfg_step_lg_lmt(3'd4),
    .cfg_lim_adc_lg(4'd3), .cfg_lim_lmt_lg(4'd2), .cfg_lim_adc_sm(4'd2),
    .cfg_lim_lmt_sm(4'd2), .cfg_lim_dsat(4'd4),
    .cfg_imm_adc(cfg_imm_adc), .cfg_imm_lmt(cfg_imm_lmt),
    .cfg_attack_dly(6'd3), .cfg_sync_en(cfg_sync_en), .cfg_period(8'd8),
    .gain_idx(gain_idx), .gain_chg(gain_chg), .st_attack(st_attack),
    .st_run(st_run), .st_inc_block(st_inc_block)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chk_gain(input string req, input int exp, input int exp_chg);
    chk(gain_idx == GAIN_W'(exp), req, int'(gain_idx), exp);
    chk(gain_chg == exp_chg[0], {req, " strobe R12"}, int'(gain_chg), exp_chg);
  endtask

  // Drop receive, then re-enter it; returns in the first running cycle.
  task automatic start_rx(input int p, input bit give_pwr, input bit attack_pulse);
    @(negedge clk);
    rx_active = 1'b0; pwr_valid = 1'b0;
    {ovl_adc_lg, ovl_adc_sm, ovl_lmt_lg, ovl_lmt_sm, dig_sat} = '0;
    repeat (2) @(negedge clk);
    chk(pwr_ready == 1'b0, "R13 ready low outside rx", int'(pwr_ready), 0);
    rx_active = 1'b1; pwr_dbfs = 7'(p); pwr_valid = give_pwr;
    @(negedge clk);
    pwr_valid = 1'b0;
    chk(st_attack == 1'b1, "R9 attack flag", int'(st_attack), 1);
    if (attack_pulse) ovl_adc_lg = 1'b1;
    @(negedge clk);
    ovl_adc_lg = 1'b0;
    repeat (ADLY) @(negedge clk);
    chk(st_run == 1'b1 && st_attack == 1'b0, "R9 running after attack", int'(st_run), 1);
  endtask

  task automatic run_vec(input int i);
    int prev;
    prev = g;
    start_rx(TBL[i][0], 1'b1, 1'b0);
    for (int k = 1; k <= 6; k++) begin
      ovl_adc_lg = (k <= TBL[i][1]);
      ovl_lmt_lg = (k <= TBL[i][2]);
      ovl_adc_sm = (k <= TBL[i][3]);
      ovl_lmt_sm = (k <= TBL[i][4]);
      dig_sat    = (k <= TBL[i][5]);
      @(negedge clk);
    end
    {ovl_adc_lg, ovl_adc_sm, ovl_lmt_lg, ovl_lmt_sm, dig_sat} = '0;
    @(negedge clk);
    chk_gain("R9 hold before tick", prev, 0);
    chk(st_inc_block == ((TBL[i][3] >= 2) || (TBL[i][4] >= 2) || (TBL[i][5] >= 4)),
        "R6 block flag", int'(st_inc_block), int'((TBL[i][3] >= 2) || (TBL[i][4] >= 2) || (TBL[i][5] >= 4)));
    @(negedge clk);
    g = TBL[i][6];
    // R2 R3 R4 R5 R6 R11 decision result
    chk_gain($sformatf("R2-R11 vector %0d", i), g, int'(g != prev));
  endtask

  task automatic do_reset();
    rx_active = 1'b0;
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    g = INIT;
  endtask

  initial begin
    do_reset();
    // R1 reset state
    chk(gain_idx == GAIN_W'(INIT), "R1 gain", int'(gain_idx), INIT);
    chk(gain_chg == 1'b0, "R1 strobe", int'(gain_chg), 0);
    chk(st_attack == 1'b0 && st_run == 1'b0, "R1 status", int'(st_run), 0);
    chk(pwr_ready == 1'b0, "R13 ready", int'(pwr_ready), 0);

    for (int i = 0; i < NV; i++) run_vec(i);

    do_reset();
    // R13: no power beat, tick passes without change
    start_rx(55, 1'b0, 1'b0);
    repeat (8) @(negedge clk);
    chk_gain("R13 no beat no decision", g, 0);

    // R8 immediate cuts; R9 pulse during attack ignored
    cfg_imm_adc = 1'b1;
    start_rx(30, 1'b1, 1'b1);
    chk_gain("R9 attack overload ignored", g, 0);
    ovl_adc_lg = 1'b1;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      g = g - 9;
      chk_gain("R8 immediate adc cut", g, 1);
    end
    ovl_adc_lg = 1'b0;
    repeat (5) @(negedge clk);
    chk_gain("R8 immediate events not counted", g, 0);
    cfg_imm_adc = 1'b0; cfg_imm_lmt = 1'b1;
    ovl_lmt_lg = 1'b1;
    @(negedge clk);
    ovl_lmt_lg = 1'b0;
    g = g - 4;
    chk_gain("R8 immediate lmt cut", g, 1);
    cfg_imm_lmt = 1'b0;

    // R7: counts do not carry across ticks
    start_rx(30, 1'b1, 1'b0);
    ovl_adc_lg = 1'b1;
    repeat (2) @(negedge clk);
    ovl_adc_lg = 1'b0;
    repeat (6) @(negedge clk);
    chk_gain("R7 first period below limit", g, 0);
    ovl_adc_lg = 1'b1;
    @(negedge clk);
    ovl_adc_lg = 1'b0;
    repeat (7) @(negedge clk);
    chk_gain("R7 counter cleared at tick", g, 0);

    // R10: sync restarts the period
    cfg_sync_en = 1'b1;
    start_rx(45, 1'b1, 1'b0);
    repeat (3) @(negedge clk);
    sync_in = 1'b1;
    @(negedge clk);
    sync_in = 1'b0;
    repeat (4) @(negedge clk);
    chk_gain("R10 old tick suppressed", g, 0);
    repeat (3) @(negedge clk);
    chk_gain("R10 still waiting", g, 0);
    @(negedge clk);
    g = g + 3;
    chk_gain("R10 tick after restart", g, 1);
    cfg_sync_en = 1'b0;

    @(negedge clk);
    rx_active = 1'b0;
    @(negedge clk);
    chk(st_run == 1'b0 && pwr_ready == 1'b0, "R9 idle outside rx", int'(st_run), 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule